// File: doc/BRIEF.md
# Decode-Stage Interlock and Operand Bypass Controller

This block is the hazard control for a five-stage in-order integer pipeline: fetch, decode with register read, execute, memory access and writeback. Every cycle it looks at the source register numbers of the instruction sitting in decode and compares them with the destination numbers carried by the instructions in execute, memory and writeback. Operands are read only in decode and written only in writeback, so read-after-write is the only dependence it has to resolve.

For ALU operands it decides in decode where each operand will come from once the instruction has moved into execute: the register file, the memory-stage result latch, or the writeback latch. It registers that choice on the same edge that moves the instruction forward. A load whose result is wanted by the very next instruction cannot be bypassed in time. In that case it raises a hold that freezes the PC and the fetch/decode latch, and it turns the execute-stage entry into a no-op for one cycle.

Conditional branches are resolved in decode. The block tests one bypassed register value against zero, with a choice of equal or not equal, and drives the next-PC redirect. The slot after a branch always executes, so a taken branch never squashes anything. When the branch operand is still being produced by an instruction in execute, or by a load in the memory stage, decode waits until the value can reach the zero test.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: When execute holds a load (`ex_load`=1, `ex_wr`=1) whose destination is non-zero and equals a decode source whose use flag is 1, `hold_fetch` and `ex_nop` are both 1 in that same cycle.
- R2: Operand selects are encoded as 0 = register file, 1 = memory-stage result, 2 = writeback result, and the code 3 never appears. If a used, non-zero decode source matches a writing execute-stage destination and no hold is raised, the select for that operand reads 1 after the next rising clock edge.
- R3: If a used, non-zero decode source matches a writing memory-stage destination, does not match the execute stage, and no hold is raised, the select reads 2 after the next rising edge.
- R4: If both execute and memory stages match the same source, the select captured is 1, because the nearer producer wins.
- R5: Register 0 never matches. A source of 0 causes no hold and captures select 0, and a branch on register 0 sees the value zero whatever the read data holds.
- R6: While `hold_fetch` is 1, both selects captured at the next edge are 0 and `pc_redirect` is 0.
- R7: A branch in decode (`id_branch`=1) whose non-zero source equals a writing execute-stage destination, or equals the destination of a writing load in the memory stage, raises `hold_fetch` and `ex_nop`.
- R8: The branch operand is taken from the memory-stage ALU result if that stage matches, otherwise from writeback data if writeback matches, otherwise from `id_rdata_a`. `pc_redirect` is 1 exactly when a branch is not held and (operand == 0) XOR `id_branch_ne`.
- R9: A source whose use flag is 0 causes no load-use hold and captures select 0.
- R10: While `rst_n` is 0 both selects read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; select registers update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_src_a | input | REG_W | First source register of the decode instruction (also the branch operand) |
| id_src_b | input | REG_W | Second source register of the decode instruction |
| id_use_a | input | 1 | First source feeds the ALU |
| id_use_b | input | 1 | Second source feeds the ALU |
| id_branch | input | 1 | Decode instruction is a conditional branch |
| id_branch_ne | input | 1 | 1: branch if operand non-zero; 0: branch if zero |
| id_rdata_a | input | XLEN | Register-file read value for the first source |
| ex_dst | input | REG_W | Destination of the execute-stage instruction |
| ex_wr | input | 1 | Execute-stage instruction writes a register |
| ex_load | input | 1 | Execute-stage instruction is a load |
| mem_dst | input | REG_W | Destination of the memory-stage instruction |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| mem_alu_res | input | XLEN | ALU result held in the memory-stage latch |
| wb_dst | input | REG_W | Destination of the writeback-stage instruction |
| wb_wr | input | 1 | Writeback-stage instruction writes a register |
| wb_data | input | XLEN | Value being written back |
| fwd_a_sel | output | 2 | Registered source select for the first ALU operand |
| fwd_b_sel | output | 2 | Registered source select for the second ALU operand |
| hold_fetch | output | 1 | Freeze PC and fetch/decode latch |
| ex_nop | output | 1 | Load a no-op into the execute-stage control |
| pc_redirect | output | 1 | Select the branch target as the next PC |

## Verification
`hold_fetch`, `ex_nop` and `pc_redirect` are combinational in the current stage contents and are due in the same cycle. The bench drives each vector on the falling edge and samples them one nanosecond later. The operand selects pass through one register, so they are due just after the following rising edge. The bench stores the expected code before that edge and compares it one nanosecond after, before the next vector is driven. A sweep of every combination of two sources and two producer destinations over an eight-register configuration, with pseudo-random flags and data, covers the match, priority and register-zero cases.

// File: rtl/pipe_hz_pkg.sv
package pipe_hz_pkg;
   typedef enum logic [1:0] {
      OPND_REGFILE  = 2'd0,
      OPND_FROM_MEM = 2'd1,
      OPND_FROM_WB  = 2'd2
   } opnd_src_e;
endpackage

// File: rtl/hz_dst_match.sv
module hz_dst_match #(
   parameter int REG_W = 5
) (
   input  logic [REG_W-1:0] src,
   input  logic [REG_W-1:0] dst,
   input  logic             wr,
   output logic             hit
);
   // register zero is hard-wired and never produces a dependence
   assign hit = wr && (src == dst) && (src != '0);
endmodule

// File: rtl/hz_interlock.sv
module hz_interlock (
   input  logic use_a,
   input  logic use_b,
   input  logic branch,
   input  logic ex_load,
   input  logic mem_load,
   input  logic hit_ex_a,
   input  logic hit_ex_b,
   input  logic hit_mem_a,
   output logic stall
);
   logic load_use;
   logic br_wait;

   always_comb begin
      load_use = ex_load && ((use_a && hit_ex_a) || (use_b && hit_ex_b));
      // branch operand cannot reach the zero test from execute, nor from a load in memory
      br_wait  = branch && (hit_ex_a || (mem_load && hit_mem_a));
      stall    = load_use || br_wait;
   end
endmodule

// File: rtl/hz_fwd_stage.sv
module hz_fwd_stage
   import pipe_hz_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      use_op,
   input  logic      hit_ex,
   input  logic      hit_mem,
   input  logic      bubble,
   output opnd_src_e sel_q
);
   opnd_src_e sel_d;

   always_comb begin
      sel_d = OPND_REGFILE;
      if (!bubble && use_op) begin
         if (hit_ex)       sel_d = OPND_FROM_MEM;
         else if (hit_mem) sel_d = OPND_FROM_WB;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q <= OPND_REGFILE;
      else        sel_q <= sel_d;
   end
endmodule

// File: rtl/hz_branch_eval.sv
module hz_branch_eval #(
   parameter int XLEN             = 32,
   parameter bit RF_WRITE_THROUGH = 1'b0
) (
   input  logic            branch,
   input  logic            cond_ne,
   input  logic            src_zero,
   input  logic            hit_mem,
   input  logic            hit_wb,
   input  logic [XLEN-1:0] rdata,
   input  logic [XLEN-1:0] mem_res,
   input  logic [XLEN-1:0] wb_res,
   input  logic            stall,
   output logic            redirect
);
   logic [XLEN-1:0] opnd;
   logic [XLEN-1:0] late_val;

   generate
      if (RF_WRITE_THROUGH) begin : g_rf_fwd
         // register file already returns the value being written this cycle
         assign late_val = rdata;
      end else begin : g_wb_byp
         assign late_val = hit_wb ? wb_res : rdata;
      end
   endgenerate

   always_comb begin
      if (src_zero)     opnd = '0;
      else if (hit_mem) opnd = mem_res;
      else              opnd = late_val;
      redirect = branch && !stall && ((opnd == '0) ^ cond_ne);
   end
endmodule

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl
   import pipe_hz_pkg::*;
#(
   parameter int REG_W            = 5,
   parameter int XLEN             = 32,
   parameter bit RF_WRITE_THROUGH = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] id_src_a,
   input  logic [REG_W-1:0] id_src_b,
   input  logic             id_use_a,
   input  logic             id_use_b,
   input  logic             id_branch,
   input  logic             id_branch_ne,
   input  logic [XLEN-1:0]  id_rdata_a,
   input  logic [REG_W-1:0] ex_dst,
   input  logic             ex_wr,
   input  logic             ex_load,
   input  logic [REG_W-1:0] mem_dst,
   input  logic             mem_wr,
   input  logic             mem_load,
   input  logic [XLEN-1:0]  mem_alu_res,
   input  logic [REG_W-1:0] wb_dst,
   input  logic             wb_wr,
   input  logic [XLEN-1:0]  wb_data,
   output logic [1:0]       fwd_a_sel,
   output logic [1:0]       fwd_b_sel,
   output logic             hold_fetch,
   output logic             ex_nop,
   output logic             pc_redirect
);
   localparam int N_OPND = 2;

   generate
      if (REG_W < 2) begin : g_bad_regw
         $error("pipe_hazard_ctl: REG_W must be at least 2");
      end
      if (XLEN < 1) begin : g_bad_xlen
         $error("pipe_hazard_ctl: XLEN must be at least 1");
      end
   endgenerate

   logic [REG_W-1:0] src    [N_OPND];
   logic             use_op [N_OPND];
   logic             hit_ex [N_OPND];
   logic             hit_mem[N_OPND];
   opnd_src_e        sel_q  [N_OPND];
   logic             hit_wb_a;
   logic             stall;

   assign src[0]    = id_src_a;
   assign src[1]    = id_src_b;
   assign use_op[0] = id_use_a;
   assign use_op[1] = id_use_b;

   generate
      for (genvar i = 0; i < N_OPND; i++) begin : g_opnd
         hz_dst_match #(.REG_W(REG_W)) u_ex_cmp (
            .src(src[i]), .dst(ex_dst), .wr(ex_wr), .hit(hit_ex[i])
         );
         hz_dst_match #(.REG_W(REG_W)) u_mem_cmp (
            .src(src[i]), .dst(mem_dst), .wr(mem_wr), .hit(hit_mem[i])
         );
         hz_fwd_stage u_sel (
            .clk(clk), .rst_n(rst_n), .use_op(use_op[i]),
            .hit_ex(hit_ex[i]), .hit_mem(hit_mem[i]),
            .bubble(stall), .sel_q(sel_q[i])
         );
      end
   endgenerate

   hz_dst_match #(.REG_W(REG_W)) u_wb_cmp (
      .src(id_src_a), .dst(wb_dst), .wr(wb_wr), .hit(hit_wb_a)
   );

   hz_interlock u_lock (
      .use_a(id_use_a), .use_b(id_use_b), .branch(id_branch),
      .ex_load(ex_load), .mem_load(mem_load),
      .hit_ex_a(hit_ex[0]), .hit_ex_b(hit_ex[1]), .hit_mem_a(hit_mem[0]),
      .stall(stall)
   );

   hz_branch_eval #(.XLEN(XLEN), .RF_WRITE_THROUGH(RF_WRITE_THROUGH)) u_br (
      .branch(id_branch), .cond_ne(id_branch_ne),
      .src_zero(id_src_a == '0), .hit_mem(hit_mem[0]), .hit_wb(hit_wb_a),
      .rdata(id_rdata_a), .mem_res(mem_alu_res), .wb_res(wb_data),
      .stall(stall), .redirect(pc_redirect)
   );

   assign fwd_a_sel  = sel_q[0];
   assign fwd_b_sel  = sel_q[1];
   assign hold_fetch = stall;
   assign ex_nop     = stall;
endmodule

// File: rtl/pipe_hazard_ctl_chk.sv
module pipe_hazard_ctl_chk #(
   parameter int REG_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic [REG_W-1:0] id_src_a,
   input logic             id_use_a,
   input logic             id_branch,
   input logic [REG_W-1:0] ex_dst,
   input logic             ex_wr,
   input logic             ex_load,
   input logic [1:0]       fwd_a_sel,
   input logic [1:0]       fwd_b_sel,
   input logic             hold_fetch,
   input logic             pc_redirect
);
   assert_load_use_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_load && ex_wr && ex_dst != '0 && id_use_a && id_src_a == ex_dst) |-> hold_fetch);

   assert_sel_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_a_sel != 2'd3) && (fwd_b_sel != 2'd3));

   assert_near_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_fetch && id_use_a && id_src_a != '0 && ex_wr && ex_dst == id_src_a)
      |=> fwd_a_sel == 2'd1);

   assert_zero_reg_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (id_src_a == '0) |=> fwd_a_sel == 2'd0);

   assert_hold_bubble_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hold_fetch |=> (fwd_a_sel == 2'd0 && fwd_b_sel == 2'd0));

   assert_hold_no_redirect_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hold_fetch |-> !pc_redirect);

   assert_branch_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (id_branch && id_src_a != '0 && ex_wr && ex_dst == id_src_a) |-> hold_fetch);
endmodule

bind pipe_hazard_ctl pipe_hazard_ctl_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/pipe_hazard_ctl_test.sv
`timescale 1ns/1ps
module pipe_hazard_ctl_test;
   localparam int RW = 3;
   localparam int XW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [RW-1:0] id_src_a = '0, id_src_b = '0, ex_dst = '0, mem_dst = '0, wb_dst = '0;
   logic          id_use_a = 0, id_use_b = 0, id_branch = 0, id_branch_ne = 0;
   logic          ex_wr = 0, ex_load = 0, mem_wr = 0, mem_load = 0, wb_wr = 0;
   logic [XW-1:0] id_rdata_a = '0, mem_alu_res = '0, wb_data = '0;
   logic [1:0]    fwd_a_sel, fwd_b_sel;
   logic          hold_fetch, ex_nop, pc_redirect;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   pipe_hazard_ctl #(.REG_W(RW), .XLEN(XW), .RF_WRITE_THROUGH(1'b0)) uut (.*);

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d (time %0t)", tag, act, exp, $time);
      end
   endtask

   function automatic bit m(input logic [RW-1:0] s, input logic [RW-1:0] d, input logic w);
      return w && s == d && s != 0;
   endfunction

   function automatic bit exp_stall();
      bit lu, bw;
      lu = ex_load && ((id_use_a && m(id_src_a, ex_dst, ex_wr)) ||
                       (id_use_b && m(id_src_b, ex_dst, ex_wr)));
      bw = id_branch && (m(id_src_a, ex_dst, ex_wr) || (mem_load && m(id_src_a, mem_dst, mem_wr)));
      return lu || bw;
   endfunction

   function automatic int exp_sel(input logic [RW-1:0] s, input logic u, input bit st);
      if (st || !u) return 0;
      if (m(s, ex_dst, ex_wr)) return 1;
      if (m(s, mem_dst, mem_wr)) return 2;
      return 0;
   endfunction

   function automatic bit exp_redir(input bit st);
      logic [XW-1:0] v;
      if (id_src_a == 0) v = '0;
      else if (m(id_src_a, mem_dst, mem_wr)) v = mem_alu_res;
      else if (m(id_src_a, wb_dst, wb_wr)) v = wb_data;
      else v = id_rdata_a;
      return id_branch && !st && ((v == 0) ^ id_branch_ne);
   endfunction

   function automatic string sel_tag(input logic [RW-1:0] s, input logic u, input bit st);
      if (st) return "R6 select under hold";
      if (!u) return "R9 unused operand";
      if (s == 0) return "R5 register zero";
      if (m(s, ex_dst, ex_wr) && m(s, mem_dst, mem_wr)) return "R4 priority";
      if (m(s, ex_dst, ex_wr)) return "R2 memory-stage select";
      if (m(s, mem_dst, mem_wr)) return "R3 writeback select";
      return "R2 register-file select";
   endfunction

   // applies current inputs: comb checks now, select checks after the next rising edge
   task automatic apply_and_check();
      bit st;
      int ea, eb;
      string ta, tb;
      #1;
      st = exp_stall();
      check(st ? "R1 R7 hold asserted" : "R9 no hold", hold_fetch, st);
      check("R1 R7 execute no-op", ex_nop, st);
      check(st ? "R6 redirect under hold" : "R8 branch redirect", pc_redirect, exp_redir(st));
      ea = exp_sel(id_src_a, id_use_a, st);
      eb = exp_sel(id_src_b, id_use_b, st);
      ta = sel_tag(id_src_a, id_use_a, st);
      tb = sel_tag(id_src_b, id_use_b, st);
      @(posedge clk);
      #1;
      check(ta, fwd_a_sel, ea);
      check(tb, fwd_b_sel, eb);
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : stim
      logic [15:0] seed;
      seed = 16'h1d3b;
      repeat (3) @(negedge clk);
      #1;
      check("R10 reset select a", fwd_a_sel, 0);
      check("R10 reset select b", fwd_b_sel, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // directed: load-use on operand b
      id_src_b = 3'd4; id_use_b = 1; ex_dst = 3'd4; ex_wr = 1; ex_load = 1;
      apply_and_check();
      // directed: both stages match, nearer wins
      ex_load = 0; id_src_a = 3'd4; id_use_a = 1; mem_dst = 3'd4; mem_wr = 1;
      apply_and_check();
      // directed: register zero in every stage
      id_src_a = 0; id_src_b = 0; ex_dst = 0; mem_dst = 0; ex_load = 1;
      apply_and_check();
      // directed: branch on writeback value, zero test taken
      ex_load = 0; ex_wr = 0; mem_wr = 0; id_branch = 1; id_branch_ne = 0;
      id_src_a = 3'd5; wb_dst = 3'd5; wb_wr = 1; wb_data = 0; id_rdata_a = 8'h11;
      apply_and_check();
      // directed: branch waiting on load in memory stage
      mem_dst = 3'd5; mem_wr = 1; mem_load = 1;
      apply_and_check();

      // sweep every source/destination combination with pseudo-random flags
      for (int k = 0; k < 4096; k++) begin
         seed = seed * 16'd25173 + 16'd13849;
         id_src_a     = k[2:0];
         id_src_b     = k[5:3];
         ex_dst       = k[8:6];
         mem_dst      = k[11:9];
         wb_dst       = 3'(k * 5 + 3);
         ex_wr        = seed[15] | seed[3];
         ex_load      = seed[14];
         mem_wr       = seed[13] | seed[2];
         mem_load     = seed[12] & seed[1];
         wb_wr        = seed[11];
         id_use_a     = seed[10] | seed[9];
         id_use_b     = seed[8] | seed[0];
         id_branch    = seed[7];
         id_branch_ne = seed[6];
         id_rdata_a   = seed[5] ? 8'h00 : 8'h3c;
         mem_alu_res  = seed[4] ? 8'h00 : 8'h81;
         wb_data      = (k % 3 == 0) ? 8'h00 : 8'h07;
         apply_and_check();
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule